// File: doc/BRIEF.md
# Daisy-Chain Priority Interrupt Unit

This block gathers interrupt requests from a row of device stages and presents them to a processor. Any pending request pulls a single shared, active-low request line low. When the processor answers with an acknowledge, the acknowledge enters stage 0 and travels down the row. Each stage lets it pass only when that stage has nothing pending. The first pending stage in its path keeps the acknowledge and puts its own fixed vector on the vector bus.

Each stage holds a pending flag. A set pulse raises the flag and a clear pulse lowers it after the device has been serviced. The set of pending stages is captured on the clock where the acknowledge is first seen high. The winner then stays fixed for the whole acknowledge, even if other requests arrive or are cleared. Vectors are computed from a base and a stride, so stage i gets base + i*stride. The chain can be built as a serial ripple or as a lookahead network. Both give the same result.

Top module: `daisy_irq_unit`

## Requirements
- R1: While reset is asserted and directly after it, `irq_n` is 1, `grant` is all zeros, `vec_bus` is zero and `ack_out` is 0.
- R2: A `req_set[i]` pulse with `req_clr[i]` low makes stage i pending from the next clock edge. `irq_n` is 0 whenever at least one stage is pending and 1 when none is.
- R3: A `req_clr[i]` pulse removes stage i's pending flag at the next edge. When set and clear are both high in the same cycle, clear wins.
- R4: `grant` can be non-zero only in the cycles from one edge after `inta` is first sampled high until one edge after it is sampled low.
- R5: Stage 0 has the highest priority. The winner is the lowest-indexed stage that was pending at the edge where `inta` was first sampled high.
- R6: A stage passes the acknowledge on toward higher indices only when it is not pending. A pending stage that receives the acknowledge blocks every later stage.
- R7: The winning stage i drives `vec_bus` = VEC_BASE + i*VEC_STEP. With the defaults this is 8'h40 + 4*i.
- R8: `vec_bus` is zero in every cycle where `grant` is zero.
- R9: At most one bit of `grant` is set at any time.
- R10: Requests that are set or cleared after the acknowledge has been captured do not change the winner until `inta` is released.
- R11: After the winner is cleared, the next acknowledge goes to the next-lowest-indexed pending stage.
- R12: `ack_out` (the acknowledge leaving the last stage) is 1 only while an acknowledge is held and no stage was captured as pending. It is never 1 together with a grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_set | input | N_STAGES | Per-stage request pulse; sets the pending flag |
| req_clr | input | N_STAGES | Per-stage service-done pulse; clears the pending flag |
| inta | input | 1 | Processor interrupt acknowledge, level, active high |
| irq_n | output | 1 | Shared interrupt request, active low |
| grant | output | N_STAGES | One-hot: the stage that holds the acknowledge |
| vec_bus | output | VEC_W | Vector of the winning stage, zero when no stage wins |
| ack_out | output | 1 | Acknowledge passed out of the last stage |

## Verification
The hardest case to reach from the ports is a change to the set of requests while an acknowledge is already held. The bench raises a higher-priority request in the middle of an acknowledge and checks that the earlier winner and its vector do not change. It then releases the acknowledge, clears that winner and acknowledges again, and checks that the new request wins. Sequences that retire several pending stages one after another show how priority falls by position, ending at the last stage. An acknowledge with nothing pending makes the acknowledge run off the end of the chain.

// File: rtl/daisy_irq_pkg.sv
package daisy_irq_pkg;

   typedef enum logic [0:0] {
      CHAIN_RIPPLE    = 1'b0,
      CHAIN_LOOKAHEAD = 1'b1
   } chain_style_e;

   function automatic int unsigned stage_vector(input int unsigned idx,
                                                input int unsigned base,
                                                input int unsigned step);
      return base + idx * step;
   endfunction

endpackage

// File: rtl/daisy_req_latch.sv
module daisy_req_latch #(
   parameter int unsigned N_STAGES = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_STAGES-1:0] set_i,
   input  logic [N_STAGES-1:0] clr_i,
   output logic [N_STAGES-1:0] pend_o
);

   for (genvar g = 0; g < N_STAGES; g++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pend_o[g] <= 1'b0;
         else if (clr_i[g])
            pend_o[g] <= 1'b0;
         else if (set_i[g])
            pend_o[g] <= 1'b1;
      end
   end

endmodule

// File: rtl/daisy_ack_capture.sv
module daisy_ack_capture #(
   parameter int unsigned N_STAGES = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                inta,
   input  logic [N_STAGES-1:0] pend_i,
   output logic                ack_live_o,
   output logic [N_STAGES-1:0] snap_o
);

   logic ack_rise;

   assign ack_rise = inta & ~ack_live_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ack_live_o <= 1'b0;
      else
         ack_live_o <= inta;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         snap_o <= '0;
      else if (ack_rise)
         snap_o <= pend_i;
   end

endmodule

// File: rtl/daisy_chain.sv
module daisy_chain
   import daisy_irq_pkg::*;
#(
   parameter int unsigned  N_STAGES    = 8,
   parameter chain_style_e CHAIN_STYLE = CHAIN_RIPPLE
) (
   input  logic                ack_i,
   input  logic [N_STAGES-1:0] snap_i,
   output logic [N_STAGES-1:0] grant_o,
   output logic                tail_o
);

   logic [N_STAGES:0] pi;

   assign pi[0] = ack_i;

   if (CHAIN_STYLE == CHAIN_RIPPLE) begin : g_ripple
      for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
         assign pi[g+1]    = pi[g] & ~snap_i[g];
         assign grant_o[g] = pi[g] &  snap_i[g];
      end
   end else begin : g_lookahead
      for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
         localparam logic [N_STAGES-1:0] UPTO = {N_STAGES{1'b1}} >> (N_STAGES - 1 - g);
         assign pi[g+1]    = ack_i & ~|(snap_i & UPTO);
         assign grant_o[g] = pi[g] & snap_i[g];
      end
   end

   assign tail_o = pi[N_STAGES];

endmodule

// File: rtl/daisy_vec_mux.sv
module daisy_vec_mux
   import daisy_irq_pkg::*;
#(
   parameter int unsigned N_STAGES  = 8,
   parameter int unsigned VEC_W     = 8,
   parameter int unsigned VEC_BASE  = 64,
   parameter int unsigned VEC_STEP  = 4
) (
   input  logic [N_STAGES-1:0] grant_i,
   output logic [VEC_W-1:0]    vec_o
);

   logic [VEC_W-1:0] term [N_STAGES];

   for (genvar g = 0; g < N_STAGES; g++) begin : g_term
      localparam logic [VEC_W-1:0] VEC = VEC_W'(stage_vector(g, VEC_BASE, VEC_STEP));
      assign term[g] = {VEC_W{grant_i[g]}} & VEC;
   end

   always_comb begin
      vec_o = '0;
      for (int k = 0; k < N_STAGES; k++)
         vec_o = vec_o | term[k];
   end

endmodule

// File: rtl/daisy_irq_unit.sv
module daisy_irq_unit
   import daisy_irq_pkg::*;
#(
   parameter int unsigned  N_STAGES    = 8,
   parameter int unsigned  VEC_W       = 8,
   parameter int unsigned  VEC_BASE    = 64,
   parameter int unsigned  VEC_STEP    = 4,
   parameter chain_style_e CHAIN_STYLE = CHAIN_RIPPLE
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_STAGES-1:0] req_set,
   input  logic [N_STAGES-1:0] req_clr,
   input  logic                inta,
   output logic                irq_n,
   output logic [N_STAGES-1:0] grant,
   output logic [VEC_W-1:0]    vec_bus,
   output logic                ack_out
);

   localparam longint unsigned TOP_VEC  = longint'(VEC_BASE) + longint'(N_STAGES - 1) * longint'(VEC_STEP);
   localparam longint unsigned VEC_SPAN = longint'(1) << VEC_W;

   if (N_STAGES < 2 || N_STAGES > 256) begin : g_bad_n
      $error("daisy_irq_unit: N_STAGES out of range");
   end
   if (VEC_W < 1 || VEC_W > 32) begin : g_bad_w
      $error("daisy_irq_unit: VEC_W out of range");
   end
   if (VEC_STEP == 0) begin : g_bad_step
      $error("daisy_irq_unit: VEC_STEP must be non-zero so vectors differ");
   end
   if (TOP_VEC >= VEC_SPAN) begin : g_bad_span
      $error("daisy_irq_unit: last vector does not fit in VEC_W bits");
   end

   logic [N_STAGES-1:0] pend;
   logic [N_STAGES-1:0] snap;
   logic                ack_live;

   daisy_req_latch #(.N_STAGES(N_STAGES)) u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (req_set),
      .clr_i  (req_clr),
      .pend_o (pend)
   );

   daisy_ack_capture #(.N_STAGES(N_STAGES)) u_capture (
      .clk        (clk),
      .rst_n      (rst_n),
      .inta       (inta),
      .pend_i     (pend),
      .ack_live_o (ack_live),
      .snap_o     (snap)
   );

   daisy_chain #(.N_STAGES(N_STAGES), .CHAIN_STYLE(CHAIN_STYLE)) u_chain (
      .ack_i   (ack_live),
      .snap_i  (snap),
      .grant_o (grant),
      .tail_o  (ack_out)
   );

   daisy_vec_mux #(
      .N_STAGES (N_STAGES),
      .VEC_W    (VEC_W),
      .VEC_BASE (VEC_BASE),
      .VEC_STEP (VEC_STEP)
   ) u_vmux (
      .grant_i (grant),
      .vec_o   (vec_bus)
   );

   assign irq_n = ~|pend;

endmodule

// File: rtl/daisy_irq_chk.sv
module daisy_irq_chk #(
   parameter int unsigned N_STAGES = 8,
   parameter int unsigned VEC_W    = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic [N_STAGES-1:0] req_set,
   input logic [N_STAGES-1:0] req_clr,
   input logic                inta,
   input logic                irq_n,
   input logic [N_STAGES-1:0] grant,
   input logic [VEC_W-1:0]    vec_bus,
   input logic                ack_out
);

   // R2: a set without a clear makes the shared line low next cycle
   p_irq_after_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (|(req_set & ~req_clr)) |=> !irq_n);

   // R3: clearing every stage releases the line, even against sets
   p_clear_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (&req_clr) |=> irq_n);

   // R4: a grant needs an acknowledge seen on the previous edge
   p_grant_needs_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|grant) |-> $past(inta));

   // R4: releasing the acknowledge ends the grant
   p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !inta |=> (grant == '0));

   // R8: no winner means an empty vector bus
   p_vec_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (grant == '0) |-> (vec_bus == '0));

   // R9: one holder at most
   p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   // R10: consecutive grant cycles keep the same winner
   p_stable_winner_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((|grant) && $past(|grant)) |-> $stable(grant));

   // R12: acknowledge leaving the chain excludes any grant
   p_tail_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
      ack_out |-> (grant == '0));

endmodule

bind daisy_irq_unit daisy_irq_chk #(.N_STAGES(N_STAGES), .VEC_W(VEC_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .req_set (req_set),
   .req_clr (req_clr),
   .inta    (inta),
   .irq_n   (irq_n),
   .grant   (grant),
   .vec_bus (vec_bus),
   .ack_out (ack_out)
);

// File: tb/daisy_irq_unit_tb_top.sv
module daisy_irq_unit_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int N          = 8;
   localparam int VW         = 8;
   localparam int BASE       = 64;
   localparam int STEP       = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  req_set = '0;
   logic [N-1:0]  req_clr = '0;
   logic          inta = 1'b0;
   logic          irq_n;
   logic [N-1:0]  grant;
   logic [VW-1:0] vec_bus;
   logic          ack_out;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   logic [N-1:0] model_pend = '0;

   // scoreboard queues
   logic [N-1:0]  exp_grant_q [$];
   logic [VW-1:0] exp_vec_q   [$];
   logic          exp_tail_q  [$];
   string         exp_tag_q   [$];
   bit            mon_arm = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   daisy_irq_unit #(.N_STAGES(N), .VEC_W(VW), .VEC_BASE(BASE), .VEC_STEP(STEP)) dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_set (req_set),
      .req_clr (req_clr),
      .inta    (inta),
      .irq_n   (irq_n),
      .grant   (grant),
      .vec_bus (vec_bus),
      .ack_out (ack_out)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: pops one expected grant item when armed
   always @(negedge clk) begin
      if (mon_arm && exp_grant_q.size() > 0) begin
         logic [N-1:0]  eg;
         logic [VW-1:0] ev;
         logic          et;
         string         tg;
         eg = exp_grant_q.pop_front();
         ev = exp_vec_q.pop_front();
         et = exp_tail_q.pop_front();
         tg = exp_tag_q.pop_front();
         check(grant == eg,   {tg, " grant"},   32'(grant),   32'(eg));
         check(vec_bus == ev, {tg, " vec_bus"}, 32'(vec_bus), 32'(ev));
         check(ack_out == et, {tg, " ack_out"}, 32'(ack_out), 32'(et));
         mon_arm = 0;
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic pulse(input logic [N-1:0] s, input logic [N-1:0] c);
      step();
      req_set = s;
      req_clr = c;
      step();
      req_set = '0;
      req_clr = '0;
      model_pend = (model_pend | s) & ~c;
   endtask

   // driver: predict winner, push it, then raise acknowledge
   task automatic push_expect(input string tag);
      logic [N-1:0] g;
      g = '0;
      for (int k = N - 1; k >= 0; k--)
         if (model_pend[k]) g = N'(1) << k;
      exp_grant_q.push_back(g);
      exp_vec_q.push_back('0);
      for (int k = 0; k < N; k++)
         if (g[k]) exp_vec_q[exp_vec_q.size()-1] = VW'(BASE + k * STEP);
      exp_tail_q.push_back(model_pend == '0);
      exp_tag_q.push_back(tag);
   endtask

   task automatic ack_begin(input string tag);
      push_expect(tag);
      step();
      inta = 1'b1;
      step();
      mon_arm = 1;
      @(negedge clk);
      #1;
   endtask

   task automatic ack_end();
      step();
      inta = 1'b0;
      step();
      @(negedge clk);
      check(grant == '0,   "R4 grant after release",  32'(grant),   0);
      check(vec_bus == '0, "R8 vec_bus after release", 32'(vec_bus), 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(irq_n == 1'b1, "R1 irq_n in reset", 32'(irq_n), 1);
      check(grant == '0,   "R1 grant in reset", 32'(grant), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(vec_bus == '0, "R1 vec_bus after reset", 32'(vec_bus), 0);
      check(ack_out == 0,  "R1 ack_out after reset", 32'(ack_out), 0);

      // R2: single request pulls the line low
      pulse(8'h20, 8'h00);
      @(negedge clk);
      check(irq_n == 1'b0, "R2 irq_n with stage 5 pending", 32'(irq_n), 0);

      // R5 R7 R6: stage 5 wins, vector 0x54
      ack_begin("R5 R7 stage5");
      // R10: higher-priority request set mid-acknowledge
      pulse(8'h04, 8'h00);
      @(negedge clk);
      check(grant == 8'h20,  "R10 grant held", 32'(grant), 32'h20);
      check(vec_bus == 8'h54, "R10 vec held",  32'(vec_bus), 32'h54);
      ack_end();

      // R3: clear stage 5, set and clear stage 7 together
      pulse(8'h80, 8'ha0);
      @(negedge clk);
      check(irq_n == 1'b0, "R3 stage 2 still pending", 32'(irq_n), 0);
      // R11: next pending stage wins
      ack_begin("R11 stage2");
      ack_end();
      pulse(8'h00, 8'h04);
      @(negedge clk);
      check(irq_n == 1'b1, "R3 all cleared", 32'(irq_n), 1);

      // R12 R6: nothing pending, acknowledge leaves the chain
      ack_begin("R12 empty chain");
      ack_end();

      // R3: simultaneous set and clear on one stage alone
      pulse(8'h02, 8'h02);
      @(negedge clk);
      check(irq_n == 1'b1, "R3 clear wins over set", 32'(irq_n), 1);

      // R5 R11: stages 0, 3, 7 retired in order
      pulse(8'h89, 8'h00);
      ack_begin("R5 stage0 first");
      ack_end();
      pulse(8'h00, 8'h01);
      ack_begin("R11 stage3 next");
      ack_end();
      pulse(8'h00, 8'h08);
      ack_begin("R7 R6 last stage7");
      ack_end();
      pulse(8'h00, 8'h80);
      @(negedge clk);
      check(irq_n == 1'b1, "R2 line high when none pending", 32'(irq_n), 1);

      check(exp_grant_q.size() == 0, "scoreboard drained", 32'(exp_grant_q.size()), 0);
      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule